// File: doc/BRIEF.md
# Accumulator ALU with Carry and Half-Carry Flags

This block is the arithmetic and logic unit of a small accumulator-style microcontroller datapath. It is purely combinational: in the same cycle, the surrounding core presents a register-file operand, the working register W, an 8-bit immediate, a 3-bit bit index, the current carry flag and a decoded operation code. The block returns the result byte, new values for the carry (C), half-carry (HC) and zero (Z) flags, and a write enable for each flag. It also returns a destination select and a zero indication that the skip instructions use.

Subtraction is built from the same adder as addition: register plus inverted W plus one. The rotates pass through the carry. Which flags an operation may change is fixed by a per-operation table, and several operations change no flag at all. The register file, the program counter and the skip sequencing are outside the block. The block only reports whether the result is zero, and it reports this before any write-back.

Top module: `acc_alu`

## Requirements
- R1: Add (OP_ADD) gives result = (reg + W) mod 256. C is the carry out of bit 7 and HC is the carry out of bit 3. All three of c_we, hc_we and z_we are 1.
- R2: Subtract (OP_SUB) gives result = (reg - W) mod 256. C = 1 exactly when reg >= W (no borrow). HC = 1 exactly when reg[3:0] >= W[3:0]. All three flag enables are 1.
- R3: Rotate right (OP_RRC) gives result = {carry_in, reg[7:1]} and C = reg[0]. Only c_we is 1.
- R4: Rotate left (OP_RLC) gives result = {reg[6:0], carry_in} and C = reg[7]. Only c_we is 1.
- R5: Nibble swap (OP_SWAP) gives result = {reg[3:0], reg[7:4]}, with all flag enables 0.
- R6: Increment (OP_INC) and decrement (OP_DEC) give reg+1 and reg-1, both mod 256, with only z_we = 1. The skip forms (OP_INCSZ, OP_DECSZ) give the same results with every flag enable 0.
- R7: AND, inclusive OR and exclusive OR take W and the register (OP_AND, OP_IOR, OP_XOR) or W and the immediate (OP_ANDI, OP_IORI, OP_XORI). Only z_we is 1.
- R8: Complement (OP_COM) gives ~reg, load (OP_MOV) gives reg, and both clears (OP_CLRW, OP_CLRR) give 0, all with only z_we = 1. Store W (OP_STW) gives W and load immediate (OP_LDI) gives the immediate, both with no flag enables.
- R9: Bit clear (OP_BCLR) and bit set (OP_BSET) force bit bit_sel of the register to 0 or 1 and leave the other bits unchanged. They have no flag enables.
- R10: dest_reg (1 = register, 0 = W) follows dest_bit for the register-with-target forms (ADD, SUB, RRC, RLC, SWAP, INC, INCSZ, DEC, DECSZ, AND, IOR, XOR, COM, MOV). It is 0 for the immediate forms and CLRW, and 1 for STW, CLRR, BCLR and BSET.
- R11: z_out and res_zero are 1 exactly when result is zero, for every operation, including those whose z_we is 0.
- R12: Whenever c_we is 0, c_out equals carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_opnd | input | 8 | Operand read from the register file |
| w_opnd | input | 8 | Working register W |
| imm_opnd | input | 8 | Immediate byte from the instruction |
| bit_sel | input | 3 | Bit index for bit clear and bit set |
| carry_in | input | 1 | Current carry flag |
| dest_bit | input | 1 | Target select from the instruction (1 = register) |
| op_code | input | 5 | Decoded operation (acc_alu_pkg::alu_op_e) |
| result | output | 8 | Result byte |
| c_out | output | 1 | New carry value |
| hc_out | output | 1 | New half-carry value |
| z_out | output | 1 | New zero value |
| c_we | output | 1 | Carry write enable |
| hc_we | output | 1 | Half-carry write enable |
| z_we | output | 1 | Zero write enable |
| dest_reg | output | 1 | 1 = write result to register, 0 = to W |
| res_zero | output | 1 | Result-is-zero indication for skip forms |

## Verification
The hardest cases to reach are the adder edges. Each depends on one exact pair of operands and does not show up often in random traffic. They are: a subtraction with equal operands (no borrow, zero result), one whose low nibbles are equal while the high ones differ, a wrap from 0xFF to 0x00 on increment-and-skip, and 0x01 to 0x00 on decrement-and-skip. The stimulus drives each of these directly before the random sweep. It also runs the rotates with both carry-in values, so that the carried bit shows in both directions. After that, every operation gets random operands, target bits and bit indices.

// File: rtl/acc_alu_pkg.sv
// Package: shared operation encoding for the accumulator ALU.
// Assumes the decoder upstream produces one of these codes per instruction.
package acc_alu_pkg;

    localparam int OP_BITS  = 5;
    localparam int OP_COUNT = 23;

    typedef enum logic [OP_BITS-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_RRC   = 5'd2,
        OP_RLC   = 5'd3,
        OP_SWAP  = 5'd4,
        OP_INC   = 5'd5,
        OP_INCSZ = 5'd6,
        OP_DEC   = 5'd7,
        OP_DECSZ = 5'd8,
        OP_AND   = 5'd9,
        OP_IOR   = 5'd10,
        OP_XOR   = 5'd11,
        OP_ANDI  = 5'd12,
        OP_IORI  = 5'd13,
        OP_XORI  = 5'd14,
        OP_COM   = 5'd15,
        OP_MOV   = 5'd16,
        OP_CLRW  = 5'd17,
        OP_CLRR  = 5'd18,
        OP_BCLR  = 5'd19,
        OP_BSET  = 5'd20,
        OP_STW   = 5'd21,
        OP_LDI   = 5'd22
    } alu_op_e;

    // Flag write enables as one bundle.
    typedef struct packed {
        logic c;
        logic hc;
        logic z;
    } flag_we_t;

    // True for operations that take the immediate in place of the register.
    function automatic logic is_imm_form(alu_op_e op);
        return (op == OP_ANDI) || (op == OP_IORI) || (op == OP_XORI) || (op == OP_LDI);
    endfunction

endpackage

// File: rtl/acc_alu_adder.sv
// Module: shared adder for add, subtract, increment and decrement.
// Produces the sum, the carry out of the top bit and the carry out of the
// lower half. Assumes WIDTH is even.
module acc_alu_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             hcout
);
    localparam int HALF = WIDTH / 2;

    logic [HALF:0]  low_sum;
    logic [WIDTH:0] full_sum;

    // Lower-half sum gives the half carry.
    always_comb low_sum = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};

    // Full-width sum gives the result and the carry.
    always_comb full_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    assign sum   = full_sum[WIDTH-1:0];
    assign cout  = full_sum[WIDTH];
    assign hcout = low_sum[HALF];
endmodule

// File: rtl/acc_alu_shift.sv
// Module: rotates through carry and nibble swap.
// Assumes WIDTH is even; the swap exchanges the two halves.
module acc_alu_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic             cin,
    output logic [WIDTH-1:0] ror,
    output logic             ror_c,
    output logic [WIDTH-1:0] rol,
    output logic             rol_c,
    output logic [WIDTH-1:0] swp
);
    localparam int HALF = WIDTH / 2;

    // Carry enters the top bit, the bottom bit leaves.
    assign ror   = {cin, a[WIDTH-1:1]};
    assign ror_c = a[0];

    // Carry enters the bottom bit, the top bit leaves.
    assign rol   = {a[WIDTH-2:0], cin};
    assign rol_c = a[WIDTH-1];

    // Exchange the two halves.
    assign swp   = {a[HALF-1:0], a[WIDTH-1:HALF]};
endmodule

// File: rtl/acc_alu_logic.sv
// Module: bitwise logic, complement and single-bit clear/set.
// x is the register or the immediate, as chosen by the top; w is W.
// Assumes idx addresses a bit that exists (WIDTH a power of two).
module acc_alu_logic #(
    parameter int WIDTH = 8,
    parameter int IDXW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] w,
    input  logic [IDXW-1:0]  idx,
    output logic [WIDTH-1:0] and_r,
    output logic [WIDTH-1:0] or_r,
    output logic [WIDTH-1:0] xor_r,
    output logic [WIDTH-1:0] com_r,
    output logic [WIDTH-1:0] bclr_r,
    output logic [WIDTH-1:0] bset_r
);
    logic [WIDTH-1:0] mask;

    // One-hot mask decoded from the bit index.
    for (genvar i = 0; i < WIDTH; i++) begin : g_mask
        assign mask[i] = (idx == IDXW'(i));
    end

    assign and_r  = x & w;
    assign or_r   = x | w;
    assign xor_r  = x ^ w;
    assign com_r  = ~x;
    assign bclr_r = x & ~mask;
    assign bset_r = x | mask;
endmodule

// File: rtl/acc_alu_ctrl.sv
// Module: per-operation flag-enable and destination table.
// Assumes op is a legal code; unknown codes write nothing and go to W.
module acc_alu_ctrl
    import acc_alu_pkg::*;
(
    input  alu_op_e  op,
    input  logic     dest_bit,
    output flag_we_t we,
    output logic     dest_reg
);
    // Which flags each operation may write.
    always_comb begin
        we = '0;
        case (op)
            OP_ADD, OP_SUB:            we = '{c: 1'b1, hc: 1'b1, z: 1'b1};
            OP_RRC, OP_RLC:            we = '{c: 1'b1, hc: 1'b0, z: 1'b0};
            OP_INC, OP_DEC,
            OP_AND, OP_IOR, OP_XOR,
            OP_ANDI, OP_IORI, OP_XORI,
            OP_COM, OP_MOV,
            OP_CLRW, OP_CLRR:          we = '{c: 1'b0, hc: 1'b0, z: 1'b1};
            default:                   we = '0;
        endcase
    end

    // Where the result goes: target bit, fixed W, or fixed register.
    always_comb begin
        case (op)
            OP_ADD, OP_SUB, OP_RRC, OP_RLC, OP_SWAP,
            OP_INC, OP_INCSZ, OP_DEC, OP_DECSZ,
            OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOV: dest_reg = dest_bit;
            OP_STW, OP_CLRR, OP_BCLR, OP_BSET:      dest_reg = 1'b1;
            default:                                dest_reg = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
// Module: combinational accumulator ALU, top level.
// Chooses the adder operands, collects the unit outputs into one result,
// and forms the flag values and the zero indication. Holds no state, so
// it takes no clock or reset. Assumes op_code carries an alu_op_e value.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDXW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]   reg_opnd,
    input  logic [WIDTH-1:0]   w_opnd,
    input  logic [WIDTH-1:0]   imm_opnd,
    input  logic [IDXW-1:0]    bit_sel,
    input  logic               carry_in,
    input  logic               dest_bit,
    input  logic [OP_BITS-1:0] op_code,
    output logic [WIDTH-1:0]   result,
    output logic               c_out,
    output logic               hc_out,
    output logic               z_out,
    output logic               c_we,
    output logic               hc_we,
    output logic               z_we,
    output logic               dest_reg,
    output logic               res_zero
);
    alu_op_e          op;
    logic [WIDTH-1:0] add_b;
    logic             add_ci;
    logic [WIDTH-1:0] sum;
    logic             add_co;
    logic             add_hc;
    logic [WIDTH-1:0] ror, rol, swp;
    logic             ror_c, rol_c;
    logic [WIDTH-1:0] x_opnd;
    logic [WIDTH-1:0] and_r, or_r, xor_r, com_r, bclr_r, bset_r;
    flag_we_t         we;

    assign op = alu_op_e'(op_code);

    // Second adder operand and carry-in per arithmetic operation.
    always_comb begin
        add_b  = w_opnd;
        add_ci = 1'b0;
        case (op)
            OP_SUB:             begin add_b = ~w_opnd;       add_ci = 1'b1; end
            OP_INC, OP_INCSZ:   begin add_b = '0;            add_ci = 1'b1; end
            OP_DEC, OP_DECSZ:   begin add_b = '1;            add_ci = 1'b0; end
            default:            begin add_b = w_opnd;        add_ci = 1'b0; end
        endcase
    end

    // Immediate replaces the register for the immediate forms.
    always_comb x_opnd = is_imm_form(op) ? imm_opnd : reg_opnd;

    acc_alu_adder #(.WIDTH(WIDTH)) u_adder (
        .a     (reg_opnd),
        .b     (add_b),
        .cin   (add_ci),
        .sum   (sum),
        .cout  (add_co),
        .hcout (add_hc)
    );

    acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .a     (reg_opnd),
        .cin   (carry_in),
        .ror   (ror),
        .ror_c (ror_c),
        .rol   (rol),
        .rol_c (rol_c),
        .swp   (swp)
    );

    acc_alu_logic #(.WIDTH(WIDTH), .IDXW(IDXW)) u_logic (
        .x      (x_opnd),
        .w      (w_opnd),
        .idx    (bit_sel),
        .and_r  (and_r),
        .or_r   (or_r),
        .xor_r  (xor_r),
        .com_r  (com_r),
        .bclr_r (bclr_r),
        .bset_r (bset_r)
    );

    acc_alu_ctrl u_ctrl (
        .op       (op),
        .dest_bit (dest_bit),
        .we       (we),
        .dest_reg (dest_reg)
    );

    // Result selection per operation.
    always_comb begin
        case (op)
            OP_ADD, OP_SUB, OP_INC,
            OP_INCSZ, OP_DEC, OP_DECSZ: result = sum;
            OP_RRC:                     result = ror;
            OP_RLC:                     result = rol;
            OP_SWAP:                    result = swp;
            OP_AND, OP_ANDI:            result = and_r;
            OP_IOR, OP_IORI:            result = or_r;
            OP_XOR, OP_XORI:            result = xor_r;
            OP_COM:                     result = com_r;
            OP_MOV:                     result = reg_opnd;
            OP_BCLR:                    result = bclr_r;
            OP_BSET:                    result = bset_r;
            OP_STW:                     result = w_opnd;
            OP_LDI:                     result = imm_opnd;
            default:                    result = '0;
        endcase
    end

    // Carry value: adder or rotate carry, otherwise the old carry.
    always_comb begin
        case (op)
            OP_ADD, OP_SUB: c_out = add_co;
            OP_RRC:         c_out = ror_c;
            OP_RLC:         c_out = rol_c;
            default:        c_out = carry_in;
        endcase
    end

    assign hc_out   = add_hc;
    assign z_out    = ~|result;
    assign res_zero = z_out;
    assign c_we     = we.c;
    assign hc_we    = we.hc;
    assign z_we     = we.z;
endmodule

// File: rtl/acc_alu_chk.sv
// Module: property checker bound to acc_alu.
// Uses immediate assertions because the block is combinational; each is
// skipped while any input it reads is unknown.
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0]   reg_opnd,
    input logic [WIDTH-1:0]   w_opnd,
    input logic               carry_in,
    input logic [OP_BITS-1:0] op_code,
    input logic [WIDTH-1:0]   result,
    input logic               c_out,
    input logic               c_we,
    input logic               hc_we,
    input logic               z_we,
    input logic               dest_reg,
    input logic               res_zero
);
    // Checks the flag, carry and destination rules for the current inputs.
    always_comb begin
        if (!$isunknown({reg_opnd, w_opnd, carry_in, op_code})) begin
            // R12
            carry_hold_chk: assert (c_we || (c_out == carry_in));
            if (op_code == OP_SUB) begin
                // R2
                sub_borrow_chk: assert (c_out == (reg_opnd >= w_opnd));
            end
            if (op_code == OP_RRC) begin
                // R3
                ror_carry_chk: assert ((c_out == reg_opnd[0]) && (result[WIDTH-1] == carry_in));
            end
            if (op_code == OP_SWAP) begin
                // R5
                swap_quiet_chk: assert (!c_we && !hc_we && !z_we);
            end
            if (op_code == OP_INCSZ) begin
                // R6
                incsz_zero_chk: assert ((res_zero == (reg_opnd == '1)) && !z_we);
            end
            if ((op_code == OP_ANDI) || (op_code == OP_IORI) ||
                (op_code == OP_XORI) || (op_code == OP_LDI)) begin
                // R10
                imm_to_w_chk: assert (!dest_reg);
            end
        end
    end
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .reg_opnd (reg_opnd),
    .w_opnd   (w_opnd),
    .carry_in (carry_in),
    .op_code  (op_code),
    .result   (result),
    .c_out    (c_out),
    .c_we     (c_we),
    .hc_we    (hc_we),
    .z_we     (z_we),
    .dest_reg (dest_reg),
    .res_zero (res_zero)
);

// File: tb/acc_alu_test.sv
// Bench: scoreboard for acc_alu. The driver applies inputs after a rising
// edge and queues the value expected from a reference model. The monitor
// compares at the next falling edge.
module acc_alu_test;
    import acc_alu_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct {
        logic [7:0] res;
        logic c, hc, z, cwe, hcwe, zwe, dreg;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_opnd = '0, w_opnd = '0, imm_opnd = '0;
    logic [2:0] bit_sel = '0;
    logic       carry_in = 1'b0, dest_bit = 1'b0;
    logic [4:0] op_code = OP_CLRW;
    logic [7:0] result;
    logic       c_out, hc_out, z_out, c_we, hc_we, z_we, dest_reg, res_zero;

    exp_t sb[$];
    int   compared = 0;
    int   mismatched = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    acc_alu uut (
        .reg_opnd (reg_opnd), .w_opnd (w_opnd), .imm_opnd (imm_opnd),
        .bit_sel  (bit_sel),  .carry_in (carry_in), .dest_bit (dest_bit),
        .op_code  (op_code),  .result (result), .c_out (c_out),
        .hc_out   (hc_out),   .z_out (z_out), .c_we (c_we), .hc_we (hc_we),
        .z_we     (z_we),     .dest_reg (dest_reg), .res_zero (res_zero)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(alu_op_e op, int r, int w, int i, int b, bit ci, bit d);
        exp_t e;
        int v;
        e.c = ci; e.hc = 1'b0; e.cwe = 0; e.hcwe = 0; e.zwe = 0; e.dreg = d;
        case (op)
            OP_ADD:   begin v = r + w; e.c = (v > 255); e.hc = ((r % 16) + (w % 16)) > 15;
                            e.cwe = 1; e.hcwe = 1; e.zwe = 1; e.tag = "R1"; end
            OP_SUB:   begin v = r - w; e.c = (r >= w); e.hc = ((r % 16) >= (w % 16));
                            e.cwe = 1; e.hcwe = 1; e.zwe = 1; e.tag = "R2"; end
            OP_RRC:   begin v = (r / 2) + (ci ? 128 : 0); e.c = r % 2; e.cwe = 1; e.tag = "R3"; end
            OP_RLC:   begin v = (r * 2) % 256 + ci; e.c = (r >= 128); e.cwe = 1; e.tag = "R4"; end
            OP_SWAP:  begin v = (r % 16) * 16 + r / 16; e.tag = "R5"; end
            OP_INC:   begin v = r + 1; e.zwe = 1; e.tag = "R6"; end
            OP_INCSZ: begin v = r + 1; e.tag = "R6"; end
            OP_DEC:   begin v = r + 255; e.zwe = 1; e.tag = "R6"; end
            OP_DECSZ: begin v = r + 255; e.tag = "R6"; end
            OP_AND:   begin v = r & w; e.zwe = 1; e.tag = "R7"; end
            OP_IOR:   begin v = r | w; e.zwe = 1; e.tag = "R7"; end
            OP_XOR:   begin v = r ^ w; e.zwe = 1; e.tag = "R7"; end
            OP_ANDI:  begin v = i & w; e.zwe = 1; e.dreg = 0; e.tag = "R7"; end
            OP_IORI:  begin v = i | w; e.zwe = 1; e.dreg = 0; e.tag = "R7"; end
            OP_XORI:  begin v = i ^ w; e.zwe = 1; e.dreg = 0; e.tag = "R7"; end
            OP_COM:   begin v = 255 - r; e.zwe = 1; e.tag = "R8"; end
            OP_MOV:   begin v = r; e.zwe = 1; e.tag = "R8"; end
            OP_CLRW:  begin v = 0; e.zwe = 1; e.dreg = 0; e.tag = "R8"; end
            OP_CLRR:  begin v = 0; e.zwe = 1; e.dreg = 1; e.tag = "R8"; end
            OP_STW:   begin v = w; e.dreg = 1; e.tag = "R8"; end
            OP_LDI:   begin v = i; e.dreg = 0; e.tag = "R8"; end
            OP_BCLR:  begin v = r & (255 - (1 << b)); e.dreg = 1; e.tag = "R9"; end
            OP_BSET:  begin v = r | (1 << b); e.dreg = 1; e.tag = "R9"; end
            default:  begin v = 0; e.tag = "R?"; end
        endcase
        e.res = v[7:0];
        e.z = (e.res == 8'd0);
        e.tag = {e.tag, "+R10+R11+R12"};
        return e;
    endfunction

    // Driver: apply one operation and queue its expected outcome.
    task automatic drive(alu_op_e op, int r, int w, int i, int b, bit ci, bit d);
        @(posedge clk);
        #1;
        reg_opnd = r[7:0]; w_opnd = w[7:0]; imm_opnd = i[7:0];
        bit_sel = b[2:0]; carry_in = ci; dest_bit = d; op_code = op;
        sb.push_back(model(op, r, w, i, b, ci, d));
    endtask

    // Monitor: compare the settled outputs with the queued item.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            compared++;
            if (result !== e.res || c_out !== e.c || z_out !== e.z || res_zero !== e.z ||
                c_we !== e.cwe || hc_we !== e.hcwe || z_we !== e.zwe ||
                dest_reg !== e.dreg || (e.hcwe && hc_out !== e.hc)) begin
                mismatched++;
                $display("FAIL %s op=%0d: got res=%h c=%b hc=%b z=%b rz=%b we=%b%b%b dr=%b, expected res=%h c=%b hc=%b z=%b rz=%b we=%b%b%b dr=%b",
                         e.tag, op_code, result, c_out, hc_out, z_out, res_zero, c_we, hc_we, z_we, dest_reg,
                         e.res, e.c, e.hc, e.z, e.z, e.cwe, e.hcwe, e.zwe, e.dreg);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #3000000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got running, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // First item after reset: all inputs zero, clear W (R8, R11).
        drive(OP_CLRW, 0, 0, 0, 0, 0, 0);
        // R1: full wrap gives C, HC and zero together; nibble-only carry.
        drive(OP_ADD, 8'hFF, 8'h01, 0, 0, 0, 1);
        drive(OP_ADD, 8'h08, 8'h08, 0, 0, 1, 0);
        // R2: equal operands, equal low nibbles, and a borrow.
        drive(OP_SUB, 8'h5A, 8'h5A, 0, 0, 0, 1);
        drive(OP_SUB, 8'h37, 8'h17, 0, 0, 0, 0);
        drive(OP_SUB, 8'h00, 8'h01, 0, 0, 1, 1);
        drive(OP_SUB, 8'h10, 8'h01, 0, 0, 0, 1);
        // R3, R4: carry in both values, bit leaving into carry.
        drive(OP_RRC, 8'h01, 0, 0, 0, 1, 1);
        drive(OP_RRC, 8'h80, 0, 0, 0, 0, 0);
        drive(OP_RLC, 8'h80, 0, 0, 0, 0, 1);
        drive(OP_RLC, 8'h01, 0, 0, 0, 1, 0);
        // R6: skip forms reaching zero, plain forms wrapping.
        drive(OP_INCSZ, 8'hFF, 0, 0, 0, 1, 1);
        drive(OP_DECSZ, 8'h01, 0, 0, 0, 0, 1);
        drive(OP_DEC, 8'h00, 0, 0, 0, 1, 0);
        // R9: top and bottom bit indices.
        drive(OP_BSET, 8'h00, 0, 0, 7, 0, 0);
        drive(OP_BCLR, 8'hFF, 0, 0, 0, 1, 0);
        // R10: immediate form ignores a target bit of 1.
        drive(OP_LDI, 8'h12, 8'h34, 8'h00, 0, 0, 1);
        drive(OP_XORI, 8'h00, 8'hC3, 8'hC3, 0, 1, 1);
        // Sweep: every operation with random operands (R1 to R12).
        for (int k = 0; k < OP_COUNT; k++) begin
            for (int n = 0; n < 40; n++) begin
                drive(alu_op_e'(k), $urandom_range(255), $urandom_range(255),
                      $urandom_range(255), $urandom_range(7),
                      $urandom_range(1), $urandom_range(1));
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule